// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block keeps, for each of several hotplug-capable buses with 32 slots apiece, two pending-request bitmaps and a mask of slots that may be removed. Firmware sees them through six 32-bit registers on a plain read/write port. An indirect select register chooses which bus the bitmaps and the mask refer to. On the other side, the platform posts plug events and unplug requests for a bus and slot. Each accepted event raises a one-cycle notification pulse toward firmware.

Firmware can also acknowledge a removal, which sends an eject request for one bus and slot back to the platform. It can fetch a slot's index value in two steps: a write latches the value from a lookup port, and a later read returns it. A platform reset pulse starts a drain sequence. The sequence ejects every pending removal one at a time and then reloads the removable mask from the platform's list of fixed slots.

Top module: `hp_status_regs`

## Requirements
- R1: Register offsets are: added bitmap 0x00, removal bitmap 0x04, eject 0x08, removable mask 0x0C, bus select 0x10, index 0x14. A read of the eject offset, or of any offset not in this list, returns 0.
- R2: While the selected bus number is not below NBUS, every read returns 0, including a read of the select register.
- R3: A read of the added bitmap returns the selected bus's pending-add bits and clears them. In legacy mode the bits are kept.
- R4: A write to the select register stores the written value, and a read returns it. In legacy mode the write stores DEF_BUS instead. After reset the select register holds DEF_BUS.
- R5: A write to the eject register takes the lowest set bit of the data as the slot and clears that slot in both bitmaps of the selected bus. One cycle later, ej_valid is high for exactly one cycle with that bus and slot.
- R6: An eject write is ignored, with no bitmap change and no ej_valid, in any of these cases: the data is zero, the selection is out of range, the selected bus is not hotpluggable, or a drain is running.
- R7: A write to the index register latches lk_value for the lowest set bit of the data as the slot. The first read of the index register returns the latched value, and the read clears it. The latched value is 0 if the data is zero, the slot is empty, the bus is not hotpluggable, or the selection is out of range.
- R8: Any register write clears the latched index value, so a read of the index register that follows any write other than an index write returns 0.
- R9: ev_plug sets bit ev_slot in the added bitmap of bus ev_bus, and ev_unplug sets it in the removal bitmap. ev_irq is high for one cycle on the next cycle. An event naming a bus not below NBUS is ignored.
- R10: After a plat_rst pulse, pending removals are ejected one per cycle, bus 0 upward and lowest slot first within a bus. Each ejected slot is also cleared in the added bitmap. Pending removals on a bus that is not hotpluggable are dropped without an eject.
- R11: When the drain finishes, each bus's removable mask equals the inverse of its fixed_slots word.
- R12: After rst_n, both bitmaps are zero, the removable masks are all ones, and ev_irq and ej_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_legacy | input | 1 | Legacy mode: the added bitmap is kept on read and the select is pinned to DEF_BUS |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects happen at the clock edge |
| reg_addr | input | 5 | Byte offset of the 32-bit register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ev_plug | input | 1 | Device-added event |
| ev_unplug | input | 1 | Removal-request event |
| ev_bus | input | EVBW | Bus number of the event |
| ev_slot | input | 5 | Slot number of the event |
| ev_irq | output | 1 | One-cycle notification pulse |
| bus_hp | input | NBUS | Per-bus hotpluggable flag |
| fixed_slots | input | NBUS*32 | Per-bus mask of slots holding non-removable devices |
| plat_rst | input | 1 | Platform reset pulse that starts the drain |
| ej_valid | output | 1 | Eject request pulse |
| ej_bus | output | BW | Bus of the eject request |
| ej_slot | output | 5 | Slot of the eject request |
| lk_bus | output | BW | Bus presented to the index lookup |
| lk_slot | output | 5 | Slot presented to the index lookup |
| lk_present | input | 1 | A device sits in the looked-up slot |
| lk_value | input | IDXW | Index value of the looked-up slot |

## Verification
The hardest state to reach is a drain that meets pending removals spread over several buses. One of those buses must be barred from hotplug, and some slots must also be pending as added. The drain must also find leftovers from earlier eject tests. The bench builds this state through ordinary unplug events across the earlier scenarios and leaves a few removals unacknowledged. It then pulses the platform reset and records every eject request in order. Finally, through the select register, it reads back each bus's bitmaps and its reloaded removable mask.

// File: rtl/hphp_pkg.sv
package hphp_pkg;
  localparam int SLOTS = 32;
  localparam logic [4:0] OFF_UP  = 5'h00;
  localparam logic [4:0] OFF_DN  = 5'h04;
  localparam logic [4:0] OFF_EJ  = 5'h08;
  localparam logic [4:0] OFF_RMV = 5'h0C;
  localparam logic [4:0] OFF_SEL = 5'h10;
  localparam logic [4:0] OFF_IDX = 5'h14;

  // lowest set bit position; 32 when the word is zero
  function automatic logic [5:0] low_slot(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd32;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

  function automatic logic [31:0] slot_bit(input logic [4:0] s);
    return 32'd1 << s;
  endfunction
endpackage

// File: rtl/hp_slot_maps.sv
module hp_slot_maps #(
  parameter int NBUS = 4,
  localparam int W = NBUS * 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] up_set,
  input  logic [W-1:0] up_clr,
  input  logic [W-1:0] dn_set,
  input  logic [W-1:0] dn_clr,
  input  logic         rmv_load,
  input  logic [W-1:0] rmv_val,
  output logic [W-1:0] up_map,
  output logic [W-1:0] dn_map,
  output logic [W-1:0] rmv_map
);
  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_map[b*32 +: 32]  <= '0;
        dn_map[b*32 +: 32]  <= '0;
        rmv_map[b*32 +: 32] <= '1;
      end else begin
        // a new event wins over a clear in the same cycle
        up_map[b*32 +: 32] <= (up_map[b*32 +: 32] & ~up_clr[b*32 +: 32]) | up_set[b*32 +: 32];
        dn_map[b*32 +: 32] <= (dn_map[b*32 +: 32] & ~dn_clr[b*32 +: 32]) | dn_set[b*32 +: 32];
        if (rmv_load) rmv_map[b*32 +: 32] <= rmv_val[b*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/hp_drain_seq.sv
module hp_drain_seq
  import hphp_pkg::*;
#(
  parameter int NBUS = 4,
  localparam int BW = $clog2(NBUS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NBUS*32-1:0] dn_map,
  input  logic [NBUS-1:0]   bus_hp,
  output logic              busy,
  output logic              fire,
  output logic              drop,
  output logic              finish,
  output logic [BW-1:0]     cur_bus,
  output logic [4:0]        cur_slot
);
  logic [BW-1:0] ptr_q;
  logic [31:0]   cur;
  logic [5:0]    lsb;
  logic          has, step;

  assign cur      = dn_map[{ptr_q, 5'd0} +: 32];
  assign lsb      = low_slot(cur);
  assign has      = |cur;
  assign cur_bus  = ptr_q;
  assign cur_slot = lsb[4:0];
  assign fire     = busy && has && bus_hp[ptr_q];
  assign drop     = busy && has && !bus_hp[ptr_q];
  assign step     = busy && !has;
  assign finish   = step && (ptr_q == BW'(NBUS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ptr_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      ptr_q <= '0;
    end else if (step) begin
      if (finish) busy <= 1'b0;
      else        ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/hp_status_regs.sv
module hp_status_regs
  import hphp_pkg::*;
#(
  parameter int NBUS    = 4,
  parameter int IDXW    = 14,
  parameter int DEF_BUS = 0,
  parameter int EVBW    = 8,
  localparam int BW = $clog2(NBUS),
  localparam int W  = NBUS * 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_legacy,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [4:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            ev_plug,
  input  logic            ev_unplug,
  input  logic [EVBW-1:0] ev_bus,
  input  logic [4:0]      ev_slot,
  output logic            ev_irq,
  input  logic [NBUS-1:0] bus_hp,
  input  logic [W-1:0]    fixed_slots,
  input  logic            plat_rst,
  output logic            ej_valid,
  output logic [BW-1:0]   ej_bus,
  output logic [4:0]      ej_slot,
  output logic [BW-1:0]   lk_bus,
  output logic [4:0]      lk_slot,
  input  logic            lk_present,
  input  logic [IDXW-1:0] lk_value
);
  logic [31:0]   sel_q;
  logic [IDXW-1:0] idx_q;
  logic          sel_ok, ev_ok;
  logic [BW-1:0] sel_b;
  logic [5:0]    wr_lsb;
  logic          up_rdclr, reg_ej, ej_now, idx_hit_ok;
  logic [BW-1:0] ej_bus_n;
  logic [4:0]    ej_slot_n;
  logic [W-1:0]  up_set, up_clr, dn_set, dn_clr, up_map, dn_map, rmv_map;
  logic          drain_busy, drn_fire, drn_drop, drn_finish;
  logic [BW-1:0] drn_bus;
  logic [4:0]    drn_slot;

  assign sel_ok = sel_q < 32'(NBUS);
  assign sel_b  = sel_q[BW-1:0];
  assign ev_ok  = ev_bus < EVBW'(NBUS);
  assign wr_lsb = low_slot(reg_wdata);
  assign lk_bus  = sel_b;
  assign lk_slot = wr_lsb[4:0];

  // register-side events
  assign up_rdclr = reg_rd && (reg_addr == OFF_UP) && sel_ok && !cfg_legacy;
  assign reg_ej   = reg_wr && (reg_addr == OFF_EJ) && sel_ok && !wr_lsb[5]
                    && bus_hp[sel_b] && !drain_busy;
  assign ej_now    = reg_ej || drn_fire;
  assign ej_bus_n  = drn_fire ? drn_bus  : sel_b;
  assign ej_slot_n = drn_fire ? drn_slot : wr_lsb[4:0];
  assign idx_hit_ok = (reg_addr == OFF_IDX) && sel_ok && !wr_lsb[5]
                      && bus_hp[sel_b] && lk_present;

  for (genvar b = 0; b < NBUS; b++) begin : g_mask
    always_comb begin
      up_set[b*32 +: 32] = (ev_plug && ev_ok && ev_bus == EVBW'(b)) ? slot_bit(ev_slot) : '0;
      dn_set[b*32 +: 32] = (ev_unplug && ev_ok && ev_bus == EVBW'(b)) ? slot_bit(ev_slot) : '0;
      up_clr[b*32 +: 32] = ((up_rdclr && sel_b == BW'(b)) ? '1 : '0)
                         | ((ej_now && ej_bus_n == BW'(b)) ? slot_bit(ej_slot_n) : '0);
      dn_clr[b*32 +: 32] = ((ej_now && ej_bus_n == BW'(b)) ? slot_bit(ej_slot_n) : '0)
                         | ((drn_drop && drn_bus == BW'(b)) ? '1 : '0);
    end
  end

  hp_slot_maps #(.NBUS(NBUS)) u_maps (
    .clk(clk), .rst_n(rst_n),
    .up_set(up_set), .up_clr(up_clr), .dn_set(dn_set), .dn_clr(dn_clr),
    .rmv_load(drn_finish), .rmv_val(~fixed_slots),
    .up_map(up_map), .dn_map(dn_map), .rmv_map(rmv_map)
  );

  hp_drain_seq #(.NBUS(NBUS)) u_drain (
    .clk(clk), .rst_n(rst_n), .start(plat_rst), .dn_map(dn_map), .bus_hp(bus_hp),
    .busy(drain_busy), .fire(drn_fire), .drop(drn_drop), .finish(drn_finish),
    .cur_bus(drn_bus), .cur_slot(drn_slot)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_ok) begin
      case (reg_addr)
        OFF_UP:  reg_rdata = up_map[{sel_b, 5'd0} +: 32];
        OFF_DN:  reg_rdata = dn_map[{sel_b, 5'd0} +: 32];
        OFF_RMV: reg_rdata = rmv_map[{sel_b, 5'd0} +: 32];
        OFF_SEL: reg_rdata = sel_q;
        OFF_IDX: reg_rdata = 32'(idx_q);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 32'(DEF_BUS);
      idx_q    <= '0;
      ev_irq   <= 1'b0;
      ej_valid <= 1'b0;
      ej_bus   <= '0;
      ej_slot  <= '0;
    end else begin
      ev_irq   <= (ev_plug || ev_unplug) && ev_ok;
      ej_valid <= ej_now;
      if (ej_now) begin
        ej_bus  <= ej_bus_n;
        ej_slot <= ej_slot_n;
      end
      if (reg_wr && reg_addr == OFF_SEL)
        sel_q <= cfg_legacy ? 32'(DEF_BUS) : reg_wdata;
      // any write wipes the latch; an index write reloads it
      if (reg_wr)
        idx_q <= idx_hit_ok ? lk_value : '0;
      else if (reg_rd && reg_addr == OFF_IDX && sel_ok)
        idx_q <= '0;
    end
  end
endmodule

// File: rtl/hp_status_checker.sv
module hp_status_checker #(
  parameter int NBUS = 4,
  parameter int IDXW = 14,
  parameter int DEF_BUS = 0,
  parameter int EVBW = 8,
  localparam int BW = $clog2(NBUS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_legacy,
  input logic            reg_wr,
  input logic [4:0]      reg_addr,
  input logic            ev_plug,
  input logic            ev_unplug,
  input logic [EVBW-1:0] ev_bus,
  input logic            ev_irq,
  input logic            ej_valid,
  input logic [BW-1:0]   ej_bus,
  input logic [NBUS-1:0] bus_hp,
  input logic [31:0]     sel_q,
  input logic [IDXW-1:0] idx_q
);
  a_r9_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_plug || ev_unplug) && ev_bus < EVBW'(NBUS)) |=> ev_irq);

  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_irq) |-> $past((ev_plug || ev_unplug) && ev_bus < EVBW'(NBUS)));

  a_r6_eject_only_hp: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> bus_hp[ej_bus]);

  a_r4_legacy_select: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'h10 && cfg_legacy) |=> (sel_q == 32'(DEF_BUS)));

  a_r8_write_wipes_index: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != 5'h14) |=> (idx_q == '0));
endmodule

bind hp_status_regs hp_status_checker #(
  .NBUS(NBUS), .IDXW(IDXW), .DEF_BUS(DEF_BUS), .EVBW(EVBW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_legacy(cfg_legacy), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .ev_plug(ev_plug), .ev_unplug(ev_unplug), .ev_bus(ev_bus),
  .ev_irq(ev_irq), .ej_valid(ej_valid), .ej_bus(ej_bus), .bus_hp(bus_hp),
  .sel_q(sel_q), .idx_q(idx_q)
);

// File: tb/sim_hp_status_regs.sv
module sim_hp_status_regs;
  localparam int NBUS = 4, IDXW = 14, BW = 2, EVBW = 8;

  logic clk = 0, rst_n = 0, cfg_legacy = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ev_plug = 0, ev_unplug = 0;
  logic [EVBW-1:0] ev_bus = 0;
  logic [4:0] ev_slot = 0;
  logic ev_irq;
  logic [NBUS-1:0] bus_hp = 4'b1011;
  logic [NBUS*32-1:0] fixed_slots;
  logic plat_rst = 0;
  logic ej_valid;
  logic [BW-1:0] ej_bus, lk_bus;
  logic [4:0] ej_slot, lk_slot;
  logic lk_present;
  logic [IDXW-1:0] lk_value;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  for (genvar b = 0; b < NBUS; b++) begin : g_fix
    assign fixed_slots[b*32 +: 32] = 32'h0000_0101 << b;
  end

  // lookup model: slots divisible by 3 are empty
  always_comb begin
    lk_present = (lk_slot % 3) != 0;
    lk_value   = IDXW'(int'(lk_bus) * 64 + int'(lk_slot) + 5);
  end

  hp_status_regs #(.NBUS(NBUS), .IDXW(IDXW), .DEF_BUS(0), .EVBW(EVBW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_legacy(cfg_legacy),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_plug(ev_plug), .ev_unplug(ev_unplug), .ev_bus(ev_bus),
    .ev_slot(ev_slot), .ev_irq(ev_irq), .bus_hp(bus_hp), .fixed_slots(fixed_slots),
    .plat_rst(plat_rst), .ej_valid(ej_valid), .ej_bus(ej_bus), .ej_slot(ej_slot),
    .lk_bus(lk_bus), .lk_slot(lk_slot), .lk_present(lk_present), .lk_value(lk_value)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic evt(input bit plug, input int bus, input int slot);
    ev_plug = plug; ev_unplug = !plug; ev_bus = EVBW'(bus); ev_slot = 5'(slot);
    @(negedge clk);
    ev_plug = 0; ev_unplug = 0;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    chk(ev_irq == 0 && ej_valid == 0, "R12 outputs idle", {ev_irq, ej_valid}, 0);
    rd(5'h00, d); chk(d == 0, "R12 added map zero", d, 0);
    rd(5'h0C, d); chk(d == 32'hFFFF_FFFF, "R12 removable all ones", d, 32'hFFFF_FFFF);
    rd(5'h10, d); chk(d == 0, "R4 select reset value", d, 0);
    rd(5'h18, d); chk(d == 0, "R1 unmapped offset", d, 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    evt(1, 1, 4);
    chk(ev_irq == 1, "R9 pulse after plug", ev_irq, 1);
    @(negedge clk);
    chk(ev_irq == 0, "R9 pulse one cycle", ev_irq, 0);
    evt(1, 7, 2);
    chk(ev_irq == 0, "R9 out-of-range bus ignored", ev_irq, 0);
    wr(5'h10, 1);
    rd(5'h10, d); chk(d == 1, "R4 select readback", d, 1);
    rd(5'h00, d); chk(d == 32'h10, "R3 added bits", d, 32'h10);
    rd(5'h00, d); chk(d == 0, "R3 cleared on read", d, 0);
    evt(0, 1, 9);
    chk(ev_irq == 1, "R9 pulse after unplug", ev_irq, 1);
    rd(5'h04, d); chk(d == 32'h200, "R9 removal bit", d, 32'h200);
    rd(5'h04, d); chk(d == 32'h200, "R1 removal map not cleared", d, 32'h200);
    rd(5'h08, d); chk(d == 0, "R1 eject reads zero", d, 0);
  endtask

  task automatic t_legacy;
    logic [31:0] d;
    cfg_legacy = 1;
    evt(1, 0, 2);
    wr(5'h10, 3);
    rd(5'h10, d); chk(d == 0, "R4 legacy select forced", d, 0);
    rd(5'h00, d); chk(d == 32'h4, "R3 legacy read", d, 32'h4);
    rd(5'h00, d); chk(d == 32'h4, "R3 legacy keeps bits", d, 32'h4);
    cfg_legacy = 0;
    rd(5'h00, d);
    rd(5'h00, d); chk(d == 0, "R3 clear after legacy off", d, 0);
  endtask

  task automatic t_out_of_range;
    logic [31:0] d;
    wr(5'h10, 9);
    rd(5'h10, d); chk(d == 0, "R2 select read hidden", d, 0);
    rd(5'h0C, d); chk(d == 0, "R2 removable read hidden", d, 0);
    wr(5'h08, 32'h1);
    chk(ej_valid == 0, "R6 no eject out of range", ej_valid, 0);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h00, d); chk(d == 0, "R2 negative select", d, 0);
  endtask

  task automatic t_eject;
    logic [31:0] d;
    wr(5'h10, 1);
    evt(1, 1, 6);
    evt(0, 1, 6);
    wr(5'h08, 32'h240);
    chk(ej_valid == 1 && ej_bus == 1 && ej_slot == 6, "R5 eject request",
        {ej_valid, 22'd0, ej_bus, ej_slot}, {1'b1, 22'd0, 2'd1, 5'd6});
    @(negedge clk);
    chk(ej_valid == 0, "R5 eject one cycle", ej_valid, 0);
    rd(5'h04, d); chk(d == 32'h200, "R5 removal bit cleared", d, 32'h200);
    rd(5'h00, d); chk(d == 0, "R5 added bit cleared", d, 0);
  endtask

  task automatic t_eject_ignored;
    logic [31:0] d;
    wr(5'h08, 0);
    chk(ej_valid == 0, "R6 zero data ignored", ej_valid, 0);
    rd(5'h04, d); chk(d == 32'h200, "R6 map untouched", d, 32'h200);
    wr(5'h10, 2);
    evt(0, 2, 1);
    wr(5'h08, 32'h2);
    chk(ej_valid == 0, "R6 non-hotplug bus ignored", ej_valid, 0);
    rd(5'h04, d); chk(d == 32'h2, "R6 non-hotplug map kept", d, 32'h2);
  endtask

  task automatic t_index;
    logic [31:0] d;
    wr(5'h10, 1);
    wr(5'h14, 32'h10);
    rd(5'h14, d); chk(d == 73, "R7 index fetched", d, 73);
    rd(5'h14, d); chk(d == 0, "R7 cleared on read", d, 0);
    wr(5'h14, 32'h8);
    rd(5'h14, d); chk(d == 0, "R7 empty slot", d, 0);
    wr(5'h14, 32'h30);
    wr(5'h10, 1);
    rd(5'h14, d); chk(d == 0, "R8 wiped by other write", d, 0);
    wr(5'h14, 0);
    rd(5'h14, d); chk(d == 0, "R7 zero data", d, 0);
    wr(5'h10, 2);
    wr(5'h14, 32'h10);
    rd(5'h14, d); chk(d == 0, "R7 non-hotplug bus", d, 0);
  endtask

  task automatic t_drain;
    logic [31:0] d;
    int seen = 0;
    logic [6:0] got [8];
    logic [6:0] exp_seq [4] = '{{2'd0, 5'd3}, {2'd0, 5'd7}, {2'd1, 5'd0}, {2'd1, 5'd9}};
    evt(0, 0, 7);
    evt(0, 0, 3);
    evt(1, 0, 7);
    evt(0, 1, 0);
    plat_rst = 1;
    @(negedge clk);
    plat_rst = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (ej_valid && seen < 8) begin
        got[seen] = {ej_bus, ej_slot};
        seen++;
      end
    end
    chk(seen == 4, "R10 eject count", 32'(seen), 4);
    for (int i = 0; i < 4; i++)
      chk(got[i] == exp_seq[i], "R10 eject order", 32'(got[i]), 32'(exp_seq[i]));
    for (int b = 0; b < NBUS; b++) begin
      wr(5'h10, 32'(b));
      rd(5'h04, d); chk(d == 0, "R10 removals drained", d, 0);
      rd(5'h0C, d);
      chk(d == ~(32'h0000_0101 << b), "R11 removable reload", d, ~(32'h0000_0101 << b));
    end
    wr(5'h10, 0);
    rd(5'h00, d); chk(d == 0, "R10 added bit cleared by drain", d, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_events();
    t_legacy();
    t_out_of_range();
    t_eject();
    t_eject_ignored();
    t_index();
    t_drain();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule